// File: doc/BRIEF.md
# Lockable Control Register with Key-Guarded Register Window

This block holds one 32-bit control word for a peripheral. Next to it sits a five-bit freeze register. Its bits can only be added to, and each bit pins one group of control fields. A key register opens or shuts the peripheral's register window. Software writes the three registers over a plain 32-bit write bus with one write per cycle, and reads them back through a combinational read port. The control word also drives the peripheral directly on `ctrl_q`.

A window state machine has two states. WIN_OPEN is entered at reset. WIN_SHUT is entered through the transition T_BAD_KEY, which is any key write whose data differs from the key parameter. T_GOOD_KEY, a key write carrying the key, returns the machine to WIN_OPEN. A good key in WIN_OPEN and a bad key in WIN_SHUT leave the state unchanged. Any other cycle also leaves the state unchanged.

A key write changes the control word even when a freeze bit is set. A good key raises bit 27 and the three-bit field 11:9. A bad key clears those same bits. While the window is shut, every read returns zero, and control or freeze writes are dropped. Key writes are still accepted.

When an accepted control write stores a value in field 11:9 other than all-zeros or all-ones, a warning output pulses for one cycle.

Top module: `ctl_lock_guard`

## Requirements
- R1: After reset the control word is 0x0C00_6000 (bits 27, 26, 14 and 13 set), the freeze register is 0, `window_enable` is 1 and `cfg_warn` is 0.
- R2: A write to the freeze register ORs data bits 4:0 into it. No write ever clears a freeze bit. Data bits 31:5 are ignored, and those bits read back as 0.
- R3: On an accepted control write, every field whose freeze bit is set keeps its old value, and all other writable bits take the written data. The freeze-bit-to-field pairs are: bit 0 with bits 6:0, bit 1 with bit 7, bit 2 with bit 8, bit 3 with bits 11:9, and bit 4 with bit 12.
- R4: A write of 0x757B_DF0D to the key register sets control bit 27 and bits 11:9, whatever the freeze bits are, and takes the window to WIN_OPEN at that clock edge.
- R5: A write of any other value to the key register clears control bit 27 and bits 11:9, whatever the freeze bits are, and takes the window to WIN_SHUT at that clock edge.
- R6: While the window is shut, `rd_data` is 0 for every address, and writes to the control and freeze registers change nothing.
- R7: Control bits 31 and 28 always read 0, and writes to them have no effect.
- R8: `cfg_warn` is 1 during exactly the one cycle after an accepted control write whose stored bits 11:9 are neither 3'b000 nor 3'b111. Otherwise it is 0.
- R9: Byte addresses are: control at 0x0, freeze at 0x4 and key at 0x8. With the window open, a read of the key address or of any unmapped address returns 0. `window_enable` is 1 exactly when the state machine is in WIN_OPEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Combinational read data |
| ctrl_q | output | 32 | Current control word, fed to the peripheral |
| window_enable | output | 1 | 1 while the register window is open |
| cfg_warn | output | 1 | One-cycle pulse on an inconsistent field 11:9 |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is low at the start, so every `$past` term looks only at post-reset state.
- Write inputs are stable around each rising edge.
- Since the bus carries only one address per cycle, a key write never coincides with a control or freeze write. The merge logic relies on this.

The bench drives all inputs one time unit after each falling edge, keeps exactly one write in flight, and holds reset for several cycles before the first write. It then steps through bad and good keys, with partial freezing in force, while a behavioural model tracks every output on each clock.

// File: rtl/ctlk_pkg.sv
package ctlk_pkg;

    localparam int CTRL_W  = 32;
    localparam int FRZ_W   = 5;
    localparam int WARN_LO = 9;
    localparam int WARN_HI = 11;

    typedef logic [CTRL_W-1:0] word_t;

    // reset image: bits 27, 26, 14, 13
    localparam word_t CTRL_RESET = 32'h0C00_6000;
    // bits that never hold data: 31 (write ignored) and 28 (reserved)
    localparam word_t FIXED_ZERO = 32'h9000_0000;
    // bits touched by a key write: 27 and 11:9
    localparam word_t KEY_TOUCH  = 32'h0800_0E00;

    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FRZ  = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_t;

    // control bits pinned by one freeze bit
    function automatic word_t frz_group(input int idx);
        word_t m;
        case (idx)
            0:       m = 32'h0000_007F;
            1:       m = 32'h0000_0080;
            2:       m = 32'h0000_0100;
            3:       m = 32'h0000_0E00;
            4:       m = 32'h0000_1000;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ctlk_decode.sv
module ctlk_decode
    import ctlk_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned FRZ_OFS  = 4,
    parameter int unsigned KEY_OFS  = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              win_open,
    output logic              ctrl_wr,
    output logic              frz_wr,
    output logic              key_wr,
    output reg_sel_t          rd_sel
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_FRZ  = ADDR_W'(FRZ_OFS);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);

    function automatic reg_sel_t map_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        if (a == A_CTRL)     s = SEL_CTRL;
        else if (a == A_FRZ) s = SEL_FRZ;
        else if (a == A_KEY) s = SEL_KEY;
        else                 s = SEL_NONE;
        return s;
    endfunction

    reg_sel_t wr_sel;

    always_comb begin
        wr_sel  = wr_en ? map_addr(wr_addr) : SEL_NONE;
        key_wr  = (wr_sel == SEL_KEY);
        ctrl_wr = win_open && (wr_sel == SEL_CTRL);
        frz_wr  = win_open && (wr_sel == SEL_FRZ);
        rd_sel  = win_open ? map_addr(rd_addr) : SEL_NONE;
    end

endmodule

// File: rtl/ctlk_window_fsm.sv
module ctlk_window_fsm
    import ctlk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic key_match,
    output logic win_open
);

    win_state_t state_q;
    win_state_t state_d;

    // next-state: T_BAD_KEY and T_GOOD_KEY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OPEN: if (key_wr && !key_match) state_d = WIN_SHUT;
            WIN_SHUT: if (key_wr &&  key_match) state_d = WIN_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WIN_OPEN: win_open = 1'b1;
            WIN_SHUT: win_open = 1'b0;
        endcase
    end

    a_r4_good_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> win_open);

    a_r5_bad_key_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> !win_open);

    a_r9_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(win_open));

endmodule

// File: rtl/ctlk_freeze_reg.sv
module ctlk_freeze_reg
    import ctlk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [FRZ_W-1:0] wr_bits,
    output logic [FRZ_W-1:0] frz_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     frz_q <= '0;
        else if (wr_ok) frz_q <= frz_q | wr_bits;
    end

    a_r2_never_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ((frz_q & $past(frz_q)) == $past(frz_q)));

    a_r6_frz_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(frz_q));

endmodule

// File: rtl/ctlk_ctrl_reg.sv
module ctlk_ctrl_reg
    import ctlk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  word_t            wr_data,
    input  logic [FRZ_W-1:0] frz_q,
    input  logic             key_wr,
    input  logic             key_match,
    output word_t            ctrl_q,
    output logic             warn_q
);

    word_t             hold_mask;
    word_t             merged;
    word_t             ctrl_d;
    logic              warn_d;
    logic [FRZ_W-1:0][CTRL_W-1:0] part;

    // one pinned-field term per freeze bit
    for (genvar g = 0; g < FRZ_W; g++) begin : g_part
        assign part[g] = frz_q[g] ? frz_group(g) : '0;
    end

    always_comb begin
        hold_mask = FIXED_ZERO;
        for (int i = 0; i < FRZ_W; i++) hold_mask = hold_mask | part[i];
    end

    always_comb begin
        merged = ((wr_data & ~hold_mask) | (ctrl_q & hold_mask)) & ~FIXED_ZERO;
        ctrl_d = ctrl_q;
        warn_d = 1'b0;
        if (key_wr) begin
            ctrl_d = key_match ? (ctrl_q | KEY_TOUCH) : (ctrl_q & ~KEY_TOUCH);
        end else if (wr_ok) begin
            ctrl_d = merged;
            warn_d = (merged[WARN_HI:WARN_LO] != '0) &&
                     (merged[WARN_HI:WARN_LO] != '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            warn_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            warn_q <= warn_d;
        end
    end

    a_r3_pinned_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (((ctrl_q ^ $past(ctrl_q)) & $past(hold_mask) & ~KEY_TOUCH) == '0));

    a_r4_key_sets_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> ((ctrl_q & KEY_TOUCH) == KEY_TOUCH));

    a_r5_key_clears_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> ((ctrl_q & KEY_TOUCH) == '0));

    a_r7_fixed_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q & FIXED_ZERO) == '0));

    a_r8_warn_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        warn_q |-> $past(wr_ok));

    a_r8_warn_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_q && !wr_ok) |=> !warn_q);

endmodule

// File: rtl/ctl_lock_guard.sv
module ctl_lock_guard
    import ctlk_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int unsigned CTRL_OFS   = 0,
    parameter int unsigned FRZ_OFS    = 4,
    parameter int unsigned KEY_OFS    = 8,
    parameter logic [31:0] UNLOCK_KEY = 32'h757B_DF0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [31:0]       ctrl_q,
    output logic              window_enable,
    output logic              cfg_warn
);

    logic             ctrl_wr;
    logic             frz_wr;
    logic             key_wr;
    logic             key_match;
    reg_sel_t         rd_sel;
    logic [FRZ_W-1:0] frz_q;

    assign key_match = (wr_data == UNLOCK_KEY);

    ctlk_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .FRZ_OFS  (FRZ_OFS),
        .KEY_OFS  (KEY_OFS)
    ) u_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .win_open (window_enable),
        .ctrl_wr  (ctrl_wr),
        .frz_wr   (frz_wr),
        .key_wr   (key_wr),
        .rd_sel   (rd_sel)
    );

    ctlk_window_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_match (key_match),
        .win_open  (window_enable)
    );

    ctlk_freeze_reg u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (frz_wr),
        .wr_bits (wr_data[FRZ_W-1:0]),
        .frz_q   (frz_q)
    );

    ctlk_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (ctrl_wr),
        .wr_data   (wr_data),
        .frz_q     (frz_q),
        .key_wr    (key_wr),
        .key_match (key_match),
        .ctrl_q    (ctrl_q),
        .warn_q    (cfg_warn)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL: rd_data = ctrl_q;
            SEL_FRZ:  rd_data = {{(32-FRZ_W){1'b0}}, frz_q};
            SEL_KEY:  rd_data = '0;
            SEL_NONE: rd_data = '0;
        endcase
    end

    a_r6_shut_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !window_enable |-> (rd_data == '0));

    a_r6_shut_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_enable && !key_wr) |=> $stable(ctrl_q));

    a_r2_upper_frz_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_FRZ) |-> (rd_data[31:FRZ_W] == '0));

endmodule

// File: tb/ctl_lock_guard_test.sv
`timescale 1ns/1ps
module ctl_lock_guard_test;

    localparam logic [3:0]  AD_CTRL = 4'h0;
    localparam logic [3:0]  AD_FRZ  = 4'h4;
    localparam logic [3:0]  AD_KEY  = 4'h8;
    localparam logic [31:0] KEY     = 32'h757B_DF0D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] ctrl_q;
    logic        window_enable;
    logic        cfg_warn;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ctl_lock_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .window_enable(window_enable), .cfg_warn(cfg_warn)
    );

    // behavioural reference model
    logic [31:0] m_ctrl;
    logic [4:0]  m_frz;
    bit          m_open;
    bit          m_warn;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] keep;
        logic [2:0]  fld;
        if (!rst_n) begin
            m_ctrl = 32'h0C00_6000; m_frz = '0; m_open = 1; m_warn = 0;
        end else begin
            m_warn = 0;
            if (wr_en && wr_addr == AD_KEY) begin
                m_open = (wr_data == KEY);
                if (m_open) m_ctrl = m_ctrl | 32'h0800_0E00;
                else        m_ctrl = m_ctrl & ~32'h0800_0E00;
            end else if (wr_en && m_open && wr_addr == AD_FRZ) begin
                m_frz = m_frz | wr_data[4:0];
            end else if (wr_en && m_open && wr_addr == AD_CTRL) begin
                keep = 32'h9000_0000;
                if (m_frz[0]) keep = keep | 32'h0000_007F;
                if (m_frz[1]) keep = keep | 32'h0000_0080;
                if (m_frz[2]) keep = keep | 32'h0000_0100;
                if (m_frz[3]) keep = keep | 32'h0000_0E00;
                if (m_frz[4]) keep = keep | 32'h0000_1000;
                m_ctrl = (wr_data & ~keep) | (m_ctrl & keep);
                fld = m_ctrl[11:9];
                m_warn = (fld != 3'b000) && (fld != 3'b111);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        if (!m_open)       return '0;
        if (a == AD_CTRL)  return m_ctrl;
        if (a == AD_FRZ)   return {27'd0, m_frz};
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // compare every clock against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 ctrl_q vs model", ctrl_q, m_ctrl);
            check("R9 window_enable vs model", {31'd0, window_enable}, {31'd0, m_open});
            check("R8 cfg_warn vs model", {31'd0, cfg_warn}, {31'd0, m_warn});
            check("R6 rd_data vs model", rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic finish_run;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        check("R1 ctrl reset", ctrl_q, 32'h0C00_6000);
        rd_check("R1 ctrl read", AD_CTRL, 32'h0C00_6000);
        rd_check("R1 freeze read", AD_FRZ, 32'h0);
        check("R1 window open", {31'd0, window_enable}, 32'd1);
        check("R1 warn low", {31'd0, cfg_warn}, 32'd0);

        // R7 fixed bits
        wr(AD_CTRL, 32'hFFFF_FFFF);
        check("R7 bits 31/28 ignored", ctrl_q, 32'h6FFF_FFFF);
        check("R8 no warn on 111", {31'd0, cfg_warn}, 32'd0);

        // R8 warning pulse
        wr(AD_CTRL, 32'h0000_0200);
        check("R8 warn pulse", {31'd0, cfg_warn}, 32'd1);
        @(negedge clk); #2;
        check("R8 warn one cycle", {31'd0, cfg_warn}, 32'd0);
        wr(AD_CTRL, 32'h0000_0000);
        check("R8 no warn on 000", {31'd0, cfg_warn}, 32'd0);

        // R2 sticky freeze bits
        wr(AD_CTRL, 32'h0000_0055);
        wr(AD_FRZ, 32'hFFFF_FFE1);
        rd_check("R2 reserved dropped", AD_FRZ, 32'h1);
        wr(AD_FRZ, 32'h0000_0004);
        rd_check("R2 OR accumulate", AD_FRZ, 32'h5);
        wr(AD_FRZ, 32'h0000_0000);
        rd_check("R2 never cleared", AD_FRZ, 32'h5);

        // R3 pinned groups 6:0 and bit 8
        wr(AD_CTRL, 32'hFFFF_FFFF);
        check("R3 partial freeze", ctrl_q, 32'h6FFF_FED5);

        // R5 bad key
        wr(AD_KEY, 32'h1234_5678);
        check("R5 window shut", {31'd0, window_enable}, 32'd0);
        check("R5 key bits cleared", ctrl_q, 32'h67FF_F0D5);
        rd_check("R6 shut ctrl read zero", AD_CTRL, 32'h0);
        rd_check("R6 shut freeze read zero", AD_FRZ, 32'h0);

        // R6 writes dropped while shut
        wr(AD_FRZ, 32'h0000_001F);
        wr(AD_CTRL, 32'h0000_0000);
        check("R6 ctrl unchanged while shut", ctrl_q, 32'h67FF_F0D5);

        // R4 good key
        wr(AD_KEY, KEY);
        check("R4 window open", {31'd0, window_enable}, 32'd1);
        check("R4 key bits set", ctrl_q, 32'h6FFF_FED5);
        rd_check("R6 freeze unchanged by shut write", AD_FRZ, 32'h5);
        wr(AD_KEY, KEY);
        check("R4 good key when open", {31'd0, window_enable}, 32'd1);

        // R9 address map
        rd_check("R9 key reads zero", AD_KEY, 32'h0);
        rd_check("R9 unmapped reads zero", 4'hC, 32'h0);
        rd_check("R9 ctrl read open", AD_CTRL, 32'h6FFF_FED5);

        // R3 all groups pinned
        wr(AD_FRZ, 32'h0000_001F);
        wr(AD_CTRL, 32'h0000_0000);
        check("R3 full freeze", ctrl_q, 32'h0000_1ED5);
        check("R8 pinned 111 no warn", {31'd0, cfg_warn}, 32'd0);

        // R5 key clears pinned field 11:9 anyway
        wr(AD_KEY, 32'h0);
        check("R5 clears despite freeze", ctrl_q, 32'h0000_10D5);
        wr(AD_KEY, KEY);
        check("R4 sets despite freeze", ctrl_q, 32'h0800_1ED5);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule